// File: doc/BRIEF.md
# Extraction Word-Stream Frame Decoder

A switch queue hands frames to a host processor as a plain stream of 32-bit words. The frame boundaries travel inside the stream as control words. This block turns that stream into a clean byte-enabled frame stream. The first `HDR_WORDS` words of each frame form an internal header. From it the block takes a 7-bit source port and a 32-bit timestamp, and both are presented as sideband on the first output beat. Every word after the header is either payload or one of eight control codes of the form `0x8000000N`. The codes mark the end of the frame, a pruned frame, an aborted frame, an escaped payload word, or an empty read.

The output is registered and has no backpressure. Each beat carries a data word, a 4-bit byte enable, a last flag and, on the last beat, a good/discard flag. The trailing four bytes of a frame are its check sequence, and the block strips them. A frame that is cut short, has too few words, or comes from an out-of-range port still ends with a last beat. On that beat the good flag is low, so the consumer can drop the frame.

Top module: `xtr_frame_decoder`

## Requirements
- R1: The first `HDR_WORDS` accepted words of each frame are header and are never interpreted as control codes, even when they equal one. Header words produce no output beat.
- R2: The source port is bits 12:6 of header bytes 27..30 read as a big-endian word. The timestamp is header bytes 2..5 as a big-endian word. Header byte 4w+j is bits [31-8j -: 8] of header word w. Both values appear on `out_src_port`/`out_tstamp`, with `out_hdr_valid` high on the first output beat of the frame only.
- R3: Payload words leave in arrival order. Every beat that is not last has `out_keep` = 4'hF.
- R4: Codes 0x80000000..0x80000003 (N=0..3) end the frame normally. The word just before the code is the check-sequence word and is not output. The last beat carries the data word before that one, with `out_keep` set to the low 4-N byte lanes (lane i = bits [8i+7:8i]), and `out_good`=1.
- R5: After the escape code 0x80000006, the next word is payload verbatim, whatever its value.
- R6: The not-ready code 0x80000007 is dropped and produces no beat. Decoding continues with the following word.
- R7: The pruned code 0x80000004 consumes one more word. The frame then ends with a discard beat: `out_last`=1, `out_keep`=0, `out_data`=0, `out_good`=0.
- R8: The abort code 0x80000005 ends the frame at once with a discard beat.
- R9: When `swap_cfg`=1, each word is byte-reversed before it is compared with the codes. Payload words are output unreversed.
- R10: A frame whose source port is `NUM_PORTS` (default 65) or more ends normally but with `out_good`=0.
- R11: An end-of-frame code after fewer than two payload words gives a discard beat.
- R12: After reset, `out_valid` is 0 and the next accepted word is header word 0, including when the reset came in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_cfg | input | 1 | Byte-reverse words before code comparison |
| in_valid | input | 1 | `in_data` holds a word this cycle |
| in_data | input | 32 | Word from the extraction queue |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Payload word |
| out_keep | output | 4 | Byte enables, lane 0 first |
| out_last | output | 1 | Final beat of the frame |
| out_good | output | 1 | Frame is good (meaningful with `out_last`) |
| out_hdr_valid | output | 1 | First beat of the frame; sideband valid |
| out_src_port | output | 7 | Source port from the header |
| out_tstamp | output | 32 | Timestamp from the header |

## Verification
On every cycle, the assertions check the structural rules of the output. A non-last beat always carries all four byte lanes, and byte enables are contiguous from lane 0. A discard beat is always last and never good, and a good beat never carries an out-of-range port. They also check the per-word reactions: header and not-ready words produce no beat, while abort and the word after a prune code produce a discard beat on the next cycle. Only the bench's frames can show the values themselves. Those are the header field extraction, the order of the data, the removal of the check-sequence word with the right byte enable, escaped code-like payload, byte-swapped comparison, runt frames, and recovery from a reset in mid-frame.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

  localparam int PORT_W = 7;

  typedef enum logic [2:0] {
    K_DATA,
    K_EOF,
    K_PRUNE,
    K_ABORT,
    K_ESC,
    K_IDLE
  } word_kind_e;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_BODY,
    ST_ESC,
    ST_PRUNE
  } dec_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/xtr_code_classify.sv
module xtr_code_classify import xtr_pkg::*; (
  input  logic [31:0] word,
  input  logic        swap,
  output word_kind_e  kind,
  output logic [2:0]  eof_bytes
);

  logic [31:0] cmp;

  always_comb begin
    cmp       = swap ? bswap32(word) : word;
    kind      = K_DATA;
    eof_bytes = 3'd4;
    if (cmp[31:3] == 29'h1000_0000) begin
      case (cmp[2:0])
        3'd4:    kind = K_PRUNE;
        3'd5:    kind = K_ABORT;
        3'd6:    kind = K_ESC;
        3'd7:    kind = K_IDLE;
        default: begin
          kind      = K_EOF;
          eof_bytes = 3'd4 - {1'b0, cmp[1:0]};
        end
      endcase
    end
  end

endmodule

// File: rtl/xtr_hdr_capture.sv
module xtr_hdr_capture import xtr_pkg::*; #(
  parameter int HDR_WORDS = 9,
  parameter int TS_OFS    = 2,
  parameter int FWD_OFS   = 27
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [$clog2(HDR_WORDS)-1:0] wr_idx,
  input  logic [31:0]                  wr_data,
  output logic [PORT_W-1:0]            src_port,
  output logic [31:0]                  tstamp
);

  localparam int IDX_W    = $clog2(HDR_WORDS);
  localparam int N_FIELD  = 8;
  localparam int PORT_LSB = 6;

  logic [7:0] fbyte [N_FIELD];

  // Only the eight bytes that hold fields are kept, each in its own register.
  for (genvar g = 0; g < N_FIELD; g++) begin : g_field
    localparam int FB = (g < 4) ? (TS_OFS + g) : (FWD_OFS + g - 4);
    always_ff @(posedge clk) begin
      if (rst)
        fbyte[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(FB / 4))
        fbyte[g] <= wr_data[31 - 8 * (FB % 4) -: 8];
    end
  end

  logic [31:0] fwd_word;

  always_comb begin
    tstamp   = {fbyte[0], fbyte[1], fbyte[2], fbyte[3]};
    fwd_word = {fbyte[4], fbyte[5], fbyte[6], fbyte[7]};
    src_port = fwd_word[PORT_LSB +: PORT_W];
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_idx) < HDR_WORDS));

endmodule

// File: rtl/xtr_beat_stage.sv
module xtr_beat_stage import xtr_pkg::*; #(
  parameter int NUM_PORTS = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [31:0]       push_data,
  input  logic              end_ok,
  input  logic [2:0]        end_bytes,
  input  logic              end_drop,
  input  logic [PORT_W-1:0] hdr_port,
  input  logic [31:0]       hdr_ts,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic [3:0]        out_keep,
  output logic              out_last,
  output logic              out_good,
  output logic              out_hdr_valid,
  output logic [PORT_W-1:0] out_src_port,
  output logic [31:0]       out_tstamp
);

  // Two-word hold: the newest word may be the check sequence.
  logic [31:0] hold_old, hold_new;
  logic [1:0]  fill;
  logic        first;

  logic        emit, emit_last, emit_good, port_ok;
  logic [31:0] emit_data;
  logic [3:0]  emit_keep;

  always_comb begin
    port_ok   = 32'(hdr_port) < NUM_PORTS;
    emit      = 1'b0;
    emit_last = 1'b0;
    emit_good = 1'b0;
    emit_data = '0;
    emit_keep = '0;
    if (push && fill == 2'd2) begin
      emit      = 1'b1;
      emit_data = hold_old;
      emit_keep = 4'hF;
    end
    if (end_ok || end_drop) begin
      emit      = 1'b1;
      emit_last = 1'b1;
      if (end_ok && fill == 2'd2) begin
        emit_data = hold_old;
        emit_keep = 4'hF >> (3'd4 - end_bytes);
        emit_good = port_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_old      <= '0;
      hold_new      <= '0;
      fill          <= '0;
      first         <= 1'b1;
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_keep      <= '0;
      out_last      <= 1'b0;
      out_good      <= 1'b0;
      out_hdr_valid <= 1'b0;
      out_src_port  <= '0;
      out_tstamp    <= '0;
    end else begin
      out_valid     <= emit;
      out_last      <= emit && emit_last;
      out_good      <= emit && emit_good;
      out_hdr_valid <= emit && first;
      if (emit) begin
        out_data     <= emit_data;
        out_keep     <= emit_keep;
        out_src_port <= hdr_port;
        out_tstamp   <= hdr_ts;
        first        <= 1'b0;
      end
      if (push) begin
        case (fill)
          2'd0: begin
            hold_old <= push_data;
            fill     <= 2'd1;
          end
          2'd1: begin
            hold_new <= push_data;
            fill     <= 2'd2;
          end
          default: begin
            hold_old <= hold_new;
            hold_new <= push_data;
          end
        endcase
      end
      if (end_ok || end_drop) begin
        fill  <= '0;
        first <= 1'b1;
      end
    end
  end

  // R3
  full_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_keep == 4'hF));
  // R4
  keep_contig_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_keep == 4'h0 || out_keep == 4'h1 || out_keep == 4'h3 ||
                   out_keep == 4'h7 || out_keep == 4'hF));
  // R7
  drop_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_keep == 4'h0) |-> (out_last && !out_good));
  // R10
  good_port_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_good) |-> (32'(out_src_port) < NUM_PORTS));
  // R2
  hdr_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_hdr_valid |-> out_valid);
  // R3
  fill_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill != 2'd3);

endmodule

// File: rtl/xtr_frame_decoder.sv
module xtr_frame_decoder import xtr_pkg::*; #(
  parameter int HDR_WORDS = 9,
  parameter int NUM_PORTS = 65,
  parameter int TS_OFS    = 2,
  parameter int FWD_OFS   = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swap_cfg,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic [3:0]        out_keep,
  output logic              out_last,
  output logic              out_good,
  output logic              out_hdr_valid,
  output logic [PORT_W-1:0] out_src_port,
  output logic [31:0]       out_tstamp
);

  localparam int IDX_W = $clog2(HDR_WORDS);

  dec_state_e        st;
  logic [IDX_W-1:0]  hdr_cnt;
  word_kind_e        kind;
  logic [2:0]        eof_bytes;
  logic              hdr_wr, push, end_ok, end_drop;
  logic [PORT_W-1:0] hdr_port;
  logic [31:0]       hdr_ts;

  xtr_code_classify u_cls (
    .word      (in_data),
    .swap      (swap_cfg),
    .kind      (kind),
    .eof_bytes (eof_bytes)
  );

  always_comb begin
    hdr_wr   = in_valid && st == ST_HDR;
    push     = in_valid && ((st == ST_BODY && kind == K_DATA) || st == ST_ESC);
    end_ok   = in_valid && st == ST_BODY && kind == K_EOF;
    end_drop = in_valid && ((st == ST_BODY && kind == K_ABORT) || st == ST_PRUNE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HDR;
      hdr_cnt <= '0;
    end else if (in_valid) begin
      case (st)
        ST_HDR: begin
          if (hdr_cnt == IDX_W'(HDR_WORDS - 1)) begin
            hdr_cnt <= '0;
            st      <= ST_BODY;
          end else begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end
        end
        ST_BODY: begin
          case (kind)
            K_EOF, K_ABORT: st <= ST_HDR;
            K_PRUNE:        st <= ST_PRUNE;
            K_ESC:          st <= ST_ESC;
            default:        st <= ST_BODY;
          endcase
        end
        ST_ESC:   st <= ST_BODY;
        default:  st <= ST_HDR;
      endcase
    end
  end

  xtr_hdr_capture #(
    .HDR_WORDS (HDR_WORDS),
    .TS_OFS    (TS_OFS),
    .FWD_OFS   (FWD_OFS)
  ) u_hdr (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (hdr_wr),
    .wr_idx   (hdr_cnt),
    .wr_data  (in_data),
    .src_port (hdr_port),
    .tstamp   (hdr_ts)
  );

  xtr_beat_stage #(
    .NUM_PORTS (NUM_PORTS)
  ) u_beat (
    .clk           (clk),
    .rst           (rst),
    .push          (push),
    .push_data     (in_data),
    .end_ok        (end_ok),
    .end_bytes     (eof_bytes),
    .end_drop      (end_drop),
    .hdr_port      (hdr_port),
    .hdr_ts        (hdr_ts),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_keep      (out_keep),
    .out_last      (out_last),
    .out_good      (out_good),
    .out_hdr_valid (out_hdr_valid),
    .out_src_port  (out_src_port),
    .out_tstamp    (out_tstamp)
  );

  // R1
  hdr_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_HDR) |=> !out_valid);
  // R6
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_BODY && kind == K_IDLE) |=> !out_valid);
  // R8
  abort_end_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_BODY && kind == K_ABORT) |=> (out_valid && out_last && !out_good));
  // R7
  prune_end_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_PRUNE) |=> (out_valid && out_last && out_keep == 4'h0));
  // R5
  esc_resume_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == ST_ESC) |=> (st == ST_BODY));

endmodule

// File: tb/xtr_frame_decoder_test.sv
module xtr_frame_decoder_test;

  localparam int HDR_WORDS = 9;
  localparam int NUM_PORTS = 65;
  localparam int NVEC      = 10;

  typedef struct packed {
    logic       swap;
    logic [7:0] nw;     // data words incl. check-sequence word
    logic [1:0] endk;   // 0 eof, 1 prune, 2 abort
    logic [1:0] eofn;
    logic [6:0] port;
    logic [31:0] ts;
    logic [7:0] esc_at; // 255 = none
    logic [7:0] nr_at;  // 255 = none
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'd5, 2'd0, 2'd0, 7'd3,  32'h1122_3344, 8'd255, 8'd255}, // R4 full word
    '{1'b0, 8'd4, 2'd0, 2'd1, 7'd10, 32'hA0B0_C0D0, 8'd255, 8'd255}, // R4 3 bytes
    '{1'b0, 8'd6, 2'd0, 2'd2, 7'd64, 32'h0000_FFFF, 8'd2,   8'd255}, // R5 R4
    '{1'b0, 8'd3, 2'd0, 2'd3, 7'd0,  32'hDEAD_BEEF, 8'd255, 8'd1},   // R6 R4
    '{1'b0, 8'd5, 2'd1, 2'd0, 7'd5,  32'h0102_0304, 8'd255, 8'd255}, // R7
    '{1'b0, 8'd4, 2'd2, 2'd0, 7'd6,  32'h0506_0708, 8'd255, 8'd255}, // R8
    '{1'b1, 8'd5, 2'd0, 2'd1, 7'd20, 32'hCAFE_F00D, 8'd1,   8'd3},   // R9
    '{1'b0, 8'd4, 2'd0, 2'd0, 7'd65, 32'h7777_0001, 8'd255, 8'd255}, // R10
    '{1'b0, 8'd1, 2'd0, 2'd0, 7'd7,  32'h0000_0001, 8'd255, 8'd255}, // R11
    '{1'b1, 8'd3, 2'd2, 2'd0, 7'd9,  32'h4242_4242, 8'd255, 8'd255}  // R9 R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        swap_cfg = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, out_last, out_good, out_hdr_valid;
  logic [31:0] out_data, out_tstamp;
  logic [3:0]  out_keep;
  logic [6:0]  out_src_port;

  always #10 clk = ~clk;

  xtr_frame_decoder #(.HDR_WORDS(HDR_WORDS), .NUM_PORTS(NUM_PORTS)) uut (
    .clk(clk), .rst(rst), .swap_cfg(swap_cfg), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
    .out_good(out_good), .out_hdr_valid(out_hdr_valid), .out_src_port(out_src_port),
    .out_tstamp(out_tstamp)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] cap_data [512];
  logic [3:0]  cap_keep [512];
  logic        cap_last [512], cap_good [512], cap_hv [512];
  logic [6:0]  cap_port [512];
  logic [31:0] cap_ts   [512];
  int          cap_n = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 512) begin
      cap_data[cap_n] <= out_data;
      cap_keep[cap_n] <= out_keep;
      cap_last[cap_n] <= out_last;
      cap_good[cap_n] <= out_good;
      cap_hv[cap_n]   <= out_hdr_valid;
      cap_port[cap_n] <= out_src_port;
      cap_ts[cap_n]   <= out_tstamp;
      cap_n           <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  function automatic logic [31:0] code(input logic sw, input logic [2:0] n);
    logic [31:0] c;
    c = 32'h8000_0000 | 32'(n);
    return sw ? {c[7:0], c[15:8], c[23:16], c[31:24]} : c;
  endfunction

  task automatic send_hdr(input logic [6:0] port, input logic [31:0] ts);
    logic [31:0] f;
    f = {19'h2A5A5, port, 6'h3F};
    for (int k = 0; k < HDR_WORDS; k++) begin
      case (k)
        0:       put({16'h0000, ts[31:16]});
        1:       put({ts[15:0], 16'hABCD});
        2:       put(32'h8000_0005);      // R1: abort-like header word
        6:       put({24'h0, f[31:24]});
        7:       put({f[23:0], 8'h5A});
        default: put(32'h8000_0000 | 32'(k));
      endcase
    end
  endtask

  task automatic run_frame(input vec_t v, input int fid);
    logic [31:0] w [64];
    int base, nexp, nl;
    base = cap_n;
    swap_cfg = v.swap;
    for (int i = 0; i < 64; i++) begin
      if (i == int'(v.esc_at))   w[i] = v.swap ? 32'h0700_0080 : 32'h8000_0007;
      else if (v.swap && i == 0) w[i] = 32'h8000_0004;  // R9: code only when unswapped
      else                       w[i] = 32'h1000_0000 | (32'(fid) << 12) | 32'(i);
    end
    send_hdr(v.port, v.ts);
    gap();
    for (int i = 0; i < int'(v.nw); i++) begin
      if (i == int'(v.nr_at)) put(code(v.swap, 3'd7));
      if (i == int'(v.esc_at)) put(code(v.swap, 3'd6));
      put(w[i]);
    end
    case (v.endk)
      2'd0: put(code(v.swap, {1'b0, v.eofn}));
      2'd1: begin put(code(v.swap, 3'd4)); put(32'h8000_0005); end
      default: put(code(v.swap, 3'd5));
    endcase
    gap();
    repeat (3) @(negedge clk);
    nl   = (int'(v.nw) >= 2) ? int'(v.nw) - 2 : 0;
    nexp = nl + 1;
    chk(cap_n - base == nexp, $sformatf("R3 frame %0d beat count", fid), 32'(cap_n - base), 32'(nexp));
    if (cap_n - base == nexp) begin
      chk(cap_hv[base] == 1'b1, "R2 hdr_valid first beat", 32'(cap_hv[base]), 1);
      chk(cap_port[base] == v.port, "R2 source port", 32'(cap_port[base]), 32'(v.port));
      chk(cap_ts[base] == v.ts, "R2 timestamp", cap_ts[base], v.ts);
      for (int b = 0; b < nl; b++) begin
        chk(cap_data[base+b] == w[b] && cap_keep[base+b] == 4'hF && !cap_last[base+b] && !cap_hv[base+b] == (b != 0),
            $sformatf("R3 frame %0d beat %0d", fid, b), cap_data[base+b], w[b]);
      end
      chk(cap_last[base+nl] == 1'b1, "R4 last flag", 32'(cap_last[base+nl]), 1);
      if (v.endk == 2'd0 && v.nw >= 2) begin
        chk(cap_data[base+nl] == w[nl], "R4 last data", cap_data[base+nl], w[nl]);
        chk(cap_keep[base+nl] == (4'hF >> v.eofn), "R4 last keep", 32'(cap_keep[base+nl]), 32'(4'hF >> v.eofn));
        chk(cap_good[base+nl] == (int'(v.port) < NUM_PORTS), "R10 good flag",
            32'(cap_good[base+nl]), 32'(int'(v.port) < NUM_PORTS));
      end else begin
        // R7 R8 R11
        chk(cap_keep[base+nl] == 4'h0 && cap_data[base+nl] == 0 && !cap_good[base+nl],
            "R7 R8 R11 discard beat", {cap_data[base+nl][27:0], cap_keep[base+nl]}, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", 32'(out_valid), 0);
    chk(cap_n == 0, "R12 no beats after reset", 32'(cap_n), 0);

    for (int i = 0; i < NVEC; i++) run_frame(VEC[i], i);

    // R12: reset in the middle of a header, then a clean frame
    put(32'h1); put(32'h2); put(32'h3);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 mid-frame reset out_valid", 32'(out_valid), 0);
    run_frame('{1'b0, 8'd4, 2'd0, 2'd0, 7'd33, 32'h5151_5151, 8'd255, 8'd255}, 20);

    // R12: reset in the middle of a body, then a clean frame
    send_hdr(7'd2, 32'h1);
    put(32'h2222_0000); put(32'h8000_0006);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_frame('{1'b0, 8'd3, 2'd0, 2'd3, 7'd44, 32'h6060_0606, 8'd255, 8'd255}, 21);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule